// File: doc/BRIEF.md
# Macro Instruction Sequencer

This block runs short macro programs held in a small instruction RAM. Software fills the RAM and sets the program length while the block is idle. A start pulse then opens a run. The run clears the eight-entry register file, loads register 1 with a start argument and sets the byte-addressed program counter to zero. From then on the block fetches one 32-bit instruction at a time and sequences it.

Arithmetic and bitfield work is done by a neighbouring datapath. The sequencer hands that datapath the decoded fields and both source register values of every issued instruction. The datapath answers in the same cycle with a writeback value. The sequencer owns the rest of the run: the register file, reads from the parameter FIFO, conditional branches with a delay slot and an annul option, and the exit flag, which also has a delay slot.

A run ends with a one-cycle done pulse. An error code is held from that pulse until the next start. It reports an illegal operation code, a fetch past the loaded program, or a branch placed in a delay slot.

Top module: `macro_seq`

## Requirements
- R1: A start pulse while idle clears all registers, loads register 1 with `start_arg`, sets the program counter to 0, clears `err_code` and raises `busy`. A start pulse while busy has no effect.
- R2: The program counter is a byte address that advances by 4 per instruction and always has bits [1:0] zero. `iss_pc` reports the address of the issued instruction.
- R3: Register 0 reads as zero. A write to register 0 is dropped. Register fields are dst [10:8], source a [13:11] and source b [16:14].
- R4: The operation code is in bits [2:0], and 7 marks a branch. A branch tests source a against zero. Bit 4 clear means the branch is taken when the value is zero; bit 4 set means it is taken when the value is nonzero. The target is the branch's own address plus the sign-extended immediate [31:14] shifted left by 2. Branches are never issued to the datapath.
- R5: A taken branch with annul bit [5] clear executes the next sequential instruction as a delay slot, then continues at the target.
- R6: A taken branch with annul bit [5] set continues at the target at once, and no delay-slot instruction runs.
- R7: An instruction with exit bit [7] set is followed by exactly one more instruction before the run ends. If that bit is set on a branch delay-slot instruction, the branch-target instruction runs once and then the run ends. The exit bit of a taken branch is ignored.
- R8: A branch in any delay slot ends the run with `err_code` = 3 and is not issued.
- R9: Operation code 6 ends the run with `err_code` = 1 and is not issued. A fetch at word index >= `prog_len` ends the run with `err_code` = 2.
- R10: Result codes [6:4] of 0, 3 and 5 write the popped FIFO word to dst. Result code 6 writes `wb_result` and also pops the FIFO. All other codes write `wb_result`. An instruction that pops is not issued while `param_valid` is low.
- R11: `done` is a one-cycle pulse at the end of every run, with `busy` low in that cycle. After reset the block is idle, with no issue, no pop and `err_code` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_we | input | 1 | Instruction RAM write strobe (honoured while idle) |
| load_addr | input | IAW | Instruction word index to write |
| load_data | input | 32 | Instruction word |
| prog_len | input | IAW+1 | Number of loaded instruction words |
| start | input | 1 | Run start pulse |
| start_arg | input | DW | Initial value for register 1 |
| param_valid | input | 1 | Parameter FIFO holds a word |
| param_data | input | DW | Parameter FIFO head |
| param_pop | output | 1 | Consume the parameter FIFO head |
| iss_valid | output | 1 | An instruction is issued this cycle |
| iss_pc | output | PCW | Byte address of the issued instruction |
| iss_op | output | 3 | Operation code |
| iss_res | output | 3 | Result code |
| iss_dst | output | 3 | Destination register |
| iss_word | output | 32 | Full instruction word for datapath field decode |
| iss_a_val | output | DW | Source a register value |
| iss_b_val | output | DW | Source b register value |
| iss_imm | output | DW | Sign-extended immediate |
| wb_result | input | DW | Datapath result for the issued instruction |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err_code | output | 2 | 0 none, 1 bad operation, 2 fetch overrun, 3 branch in slot |

## Verification
A corrupted register file shows on `iss_a_val` or `iss_b_val` at the first later instruction that reads that register. A wrong program counter or slot state shows at once on `iss_pc`, because a skipped delay slot, an extra slot or a wrong target changes the address of the very next issue. A lost or extra FIFO pop moves every later fetched parameter by one word. A wrong run-end decision shows in the cycle of the `done` pulse as an issue count or `err_code` that does not match.

// File: rtl/macro_seq_pkg.sv
package macro_seq_pkg;

  localparam int unsigned INSN_W  = 32;
  localparam int unsigned REG_AW  = 3;
  localparam int unsigned NUM_REG = 1 << REG_AW;
  localparam int unsigned IMM_W   = 18;

  typedef enum logic [2:0] {
    OP_ALU    = 3'd0,
    OP_ADDI   = 3'd1,
    OP_BFINS  = 3'd2,
    OP_BFSLI  = 3'd3,
    OP_BFSLR  = 3'd4,
    OP_READ   = 3'd5,
    OP_RSVD   = 3'd6,
    OP_BRANCH = 3'd7
  } op_e;

  localparam logic [2:0] RES_FETCH_ONLY   = 3'd0;
  localparam logic [2:0] RES_FETCH_SEND   = 3'd3;
  localparam logic [2:0] RES_FETCH_METHOD = 3'd5;
  localparam logic [2:0] RES_SEND_PARAM   = 3'd6;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_EXEC} state_e;
  typedef enum logic [1:0] {SLOT_NONE, SLOT_BRANCH, SLOT_LAST} slot_e;
  typedef enum logic [1:0] {
    ERR_NONE     = 2'd0,
    ERR_OPCODE   = 2'd1,
    ERR_OVERRUN  = 2'd2,
    ERR_SLOT_BR  = 2'd3
  } err_e;

  typedef struct packed {
    op_e              op;
    logic [2:0]       res;
    logic             exit_f;
    logic [REG_AW-1:0] dst;
    logic [REG_AW-1:0] ra;
    logic [REG_AW-1:0] rb;
    logic [IMM_W-1:0] imm;
    logic             br_nz;
    logic             br_annul;
    logic             is_branch;
    logic             legal;
    logic             from_param;
    logic             pops;
  } dec_t;

endpackage

// File: rtl/macro_seq_imem.sv
module macro_seq_imem #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/macro_seq_decode.sv
module macro_seq_decode
  import macro_seq_pkg::*;
(
  input  logic [INSN_W-1:0] word,
  output dec_t              dec
);

  always_comb begin
    dec.op         = op_e'(word[2:0]);
    dec.res        = word[6:4];
    dec.exit_f     = word[7];
    dec.dst        = word[10:8];
    dec.ra         = word[13:11];
    dec.rb         = word[16:14];
    dec.imm        = word[31:14];
    dec.br_nz      = word[4];
    dec.br_annul   = word[5];
    dec.is_branch  = (dec.op == OP_BRANCH);
    dec.legal      = (dec.op != OP_RSVD);
    dec.from_param = !dec.is_branch &&
                     ((dec.res == RES_FETCH_ONLY) ||
                      (dec.res == RES_FETCH_SEND) ||
                      (dec.res == RES_FETCH_METHOD));
    dec.pops       = dec.from_param ||
                     (!dec.is_branch && (dec.res == RES_SEND_PARAM));
  end

endmodule

// File: rtl/macro_seq_regfile.sv
module macro_seq_regfile #(
  parameter int unsigned DW    = 32,
  parameter int unsigned NREGS = 8,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          clr,
  input  logic [DW-1:0] init_r1,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b
);

  logic [DW-1:0] regs_q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs_q[g] = '0;
    end else begin : g_store
      always_ff @(posedge clk) begin
        if (clr)
          regs_q[g] <= (g == 1) ? init_r1 : '0;
        else if (we && (waddr == AW'(g)))
          regs_q[g] <= wdata;
      end
    end
  end

  assign rd_a = regs_q[ra_a];
  assign rd_b = regs_q[ra_b];

endmodule

// File: rtl/macro_seq.sv
module macro_seq
  import macro_seq_pkg::*;
#(
  parameter int unsigned IMEM_DEPTH = 256,
  parameter int unsigned DW         = 32,
  localparam int unsigned IAW       = $clog2(IMEM_DEPTH),
  localparam int unsigned PCW       = IAW + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_we,
  input  logic [IAW-1:0]   load_addr,
  input  logic [31:0]      load_data,
  input  logic [IAW:0]     prog_len,
  input  logic             start,
  input  logic [DW-1:0]    start_arg,
  input  logic             param_valid,
  input  logic [DW-1:0]    param_data,
  output logic             param_pop,
  output logic             iss_valid,
  output logic [PCW-1:0]   iss_pc,
  output logic [2:0]       iss_op,
  output logic [2:0]       iss_res,
  output logic [2:0]       iss_dst,
  output logic [31:0]      iss_word,
  output logic [DW-1:0]    iss_a_val,
  output logic [DW-1:0]    iss_b_val,
  output logic [DW-1:0]    iss_imm,
  input  logic [DW-1:0]    wb_result,
  output logic             busy,
  output logic             done,
  output logic [1:0]       err_code
);

  state_e          state_q;
  slot_e           slot_q, slot_d;
  logic [PCW-1:0]  pc_q, pc_d, tgt_q, tgt_d;
  logic            done_q;
  err_e            err_q;

  logic [INSN_W-1:0] iword;
  dec_t              dec;
  logic [DW-1:0]     rd_a, rd_b;

  logic            overrun, bad, stall, go, taken, a_zero, launch, rf_we;
  logic [PCW-1:0]  seq_pc, jump_pc;

  assign launch  = (state_q == ST_IDLE) && start;
  assign overrun = ({1'b0, pc_q[PCW-1:2]} >= prog_len);

  macro_seq_imem #(.DEPTH(IMEM_DEPTH), .DW(INSN_W)) u_imem (
    .clk   (clk),
    .we    (load_we && (state_q == ST_IDLE)),
    .waddr (load_addr),
    .wdata (load_data),
    .re    ((state_q == ST_FETCH) && !overrun),
    .raddr (pc_q[PCW-1:2]),
    .rdata (iword)
  );

  macro_seq_decode u_dec (
    .word (iword),
    .dec  (dec)
  );

  macro_seq_regfile #(.DW(DW), .NREGS(NUM_REG)) u_rf (
    .clk     (clk),
    .clr     (launch),
    .init_r1 (start_arg),
    .we      (rf_we),
    .waddr   (dec.dst),
    .wdata   (dec.from_param ? param_data : wb_result),
    .ra_a    (dec.ra),
    .ra_b    (dec.rb),
    .rd_a    (rd_a),
    .rd_b    (rd_b)
  );

  // Execution decisions for the instruction held in the RAM output register
  assign a_zero  = (rd_a == '0);
  assign taken   = dec.is_branch && (dec.br_nz ? !a_zero : a_zero);
  assign seq_pc  = pc_q + PCW'(4);
  assign jump_pc = pc_q + {dec.imm[PCW-3:0], 2'b00};
  assign bad     = !dec.legal || (dec.is_branch && (slot_q != SLOT_NONE));
  assign stall   = dec.pops && !param_valid;
  assign go      = (state_q == ST_EXEC) && !bad && !stall;
  assign rf_we   = go && !dec.is_branch;

  // Next program counter and slot kind
  always_comb begin
    pc_d   = seq_pc;
    slot_d = SLOT_NONE;
    tgt_d  = tgt_q;
    case (slot_q)
      SLOT_BRANCH: begin
        pc_d   = tgt_q;
        slot_d = dec.exit_f ? SLOT_LAST : SLOT_NONE;
      end
      SLOT_LAST: begin
        slot_d = SLOT_NONE;
      end
      default: begin
        if (taken) begin
          if (dec.br_annul) begin
            pc_d = jump_pc;
          end else begin
            tgt_d  = jump_pc;
            slot_d = SLOT_BRANCH;
          end
        end else begin
          slot_d = dec.exit_f ? SLOT_LAST : SLOT_NONE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      slot_q  <= SLOT_NONE;
      pc_q    <= '0;
      tgt_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= ERR_NONE;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_FETCH;
            slot_q  <= SLOT_NONE;
            pc_q    <= '0;
            err_q   <= ERR_NONE;
          end
        end
        ST_FETCH: begin
          if (overrun) begin
            err_q   <= ERR_OVERRUN;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          if (bad) begin
            err_q   <= dec.legal ? ERR_SLOT_BR : ERR_OPCODE;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (!stall) begin
            pc_q   <= pc_d;
            slot_q <= slot_d;
            tgt_q  <= tgt_d;
            if (slot_q == SLOT_LAST) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_FETCH;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign iss_valid = go && !dec.is_branch;
  assign param_pop = iss_valid && dec.pops;
  assign iss_pc    = pc_q;
  assign iss_op    = dec.op;
  assign iss_res   = dec.res;
  assign iss_dst   = dec.dst;
  assign iss_word  = iword;
  assign iss_a_val = rd_a;
  assign iss_b_val = rd_b;
  assign iss_imm   = {{(DW-IMM_W){dec.imm[IMM_W-1]}}, dec.imm};
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign err_code  = err_q;

endmodule

// File: rtl/macro_seq_chk.sv
module macro_seq_chk #(
  parameter int unsigned IMEM_DEPTH = 256,
  parameter int unsigned DW         = 32,
  localparam int unsigned PCW       = $clog2(IMEM_DEPTH) + 2
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           param_valid,
  input logic           param_pop,
  input logic           iss_valid,
  input logic [PCW-1:0] iss_pc,
  input logic [31:0]    iss_word,
  input logic [DW-1:0]  iss_a_val,
  input logic           busy,
  input logic           done,
  input logic [1:0]     err_code
);

  // R1: an accepted start opens a run
  a_r1_start_opens_run: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R1: a fresh run begins with a clear error code
  a_r1_err_cleared: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (err_code == 2'd0));

  // R2: program counter stays word aligned during a run
  a_r2_pc_aligned: assert property (@(posedge clk) disable iff (rst)
    busy |-> (iss_pc[1:0] == 2'b00));

  // R2: issues only happen inside a run
  a_r2_issue_in_run: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> busy);

  // R3: register 0 always reads as zero
  a_r3_zero_reg: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && (iss_word[13:11] == 3'd0)) |-> (iss_a_val == '0));

  // R9: a new nonzero error code coincides with the end of a run
  a_r9_err_at_done: assert property (@(posedge clk) disable iff (rst)
    ((err_code != $past(err_code)) && (err_code != 2'd0)) |-> done);

  // R10: a pop never happens on an empty FIFO
  a_r10_pop_has_data: assert property (@(posedge clk) disable iff (rst)
    param_pop |-> param_valid);

  // R10: a pop always belongs to an issued instruction
  a_r10_pop_on_issue: assert property (@(posedge clk) disable iff (rst)
    param_pop |-> iss_valid);

  // R11: done lasts one cycle
  a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11: the block is idle when done is shown
  a_r11_idle_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

endmodule

bind macro_seq macro_seq_chk #(.IMEM_DEPTH(IMEM_DEPTH), .DW(DW)) u_macro_seq_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .param_valid (param_valid),
  .param_pop   (param_pop),
  .iss_valid   (iss_valid),
  .iss_pc      (iss_pc),
  .iss_word    (iss_word),
  .iss_a_val   (iss_a_val),
  .busy        (busy),
  .done        (done),
  .err_code    (err_code)
);

// File: tb/test_macro_seq.sv
module test_macro_seq;

  localparam int DEPTH  = 256;
  localparam int DW     = 32;
  localparam int IAW    = $clog2(DEPTH);
  localparam int PCW    = IAW + 2;
  localparam int PCMASK = (1 << PCW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load_we = 1'b0;
  logic [IAW-1:0] load_addr = '0;
  logic [31:0] load_data = '0;
  logic [IAW:0] prog_len = '0;
  logic start = 1'b0;
  logic [DW-1:0] start_arg = '0;
  logic param_valid = 1'b0;
  logic [DW-1:0] param_data;
  logic param_pop, iss_valid, busy, done;
  logic [PCW-1:0] iss_pc;
  logic [2:0] iss_op, iss_res, iss_dst;
  logic [31:0] iss_word;
  logic [DW-1:0] iss_a_val, iss_b_val, iss_imm, wb_result;
  logic [1:0] err_code;

  int errors = 0;
  int checks = 0;
  bit pv_block = 1'b0;
  bit pidx_clr = 1'b0;
  int pidx = 0;

  logic [31:0] prog_m [DEPTH];
  int exp_n, exp_err;
  int exp_pc [256];
  logic [31:0] exp_a [256], exp_b [256];
  int got_n = 0;
  int got_pc [256];
  logic [31:0] got_a [256], got_b [256];

  always #5 clk = ~clk;

  macro_seq #(.IMEM_DEPTH(DEPTH), .DW(DW)) i_macro_seq (
    .clk(clk), .rst(rst), .load_we(load_we), .load_addr(load_addr),
    .load_data(load_data), .prog_len(prog_len), .start(start),
    .start_arg(start_arg), .param_valid(param_valid), .param_data(param_data),
    .param_pop(param_pop), .iss_valid(iss_valid), .iss_pc(iss_pc),
    .iss_op(iss_op), .iss_res(iss_res), .iss_dst(iss_dst), .iss_word(iss_word),
    .iss_a_val(iss_a_val), .iss_b_val(iss_b_val), .iss_imm(iss_imm),
    .wb_result(wb_result), .busy(busy), .done(done), .err_code(err_code)
  );

  // Bench datapath: answer is a + b + imm in the issue cycle
  assign wb_result = iss_a_val + iss_b_val + iss_imm;

  function automatic logic [31:0] pval(input int idx);
    return (32'(idx) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  assign param_data = pval(pidx);

  always @(posedge clk) begin
    if (pidx_clr) pidx <= 0;
    else if (param_pop) pidx <= pidx + 1;
  end

  initial begin
    forever begin
      @(posedge clk);
      #1;
      param_valid = !pv_block && (($urandom % 4) != 0);
    end
  end

  always @(negedge clk) begin
    if (start && !busy) got_n = 0;
    if (iss_valid) begin
      if (got_n < 256) begin
        got_pc[got_n] = int'(iss_pc);
        got_a[got_n]  = iss_a_val;
        got_b[got_n]  = iss_b_val;
      end
      got_n = got_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkop(input int op, input int res, input int dst,
                                       input int a, input int b, input bit ex);
    logic [31:0] w = '0;
    w[2:0] = 3'(op); w[6:4] = 3'(res); w[7] = ex;
    w[10:8] = 3'(dst); w[13:11] = 3'(a); w[16:14] = 3'(b);
    return w;
  endfunction

  function automatic logic [31:0] mkbr(input int a, input bit nz, input bit annul,
                                       input int imm, input bit ex);
    logic [31:0] w = '0;
    w[2:0] = 3'd7; w[4] = nz; w[5] = annul; w[7] = ex;
    w[13:11] = 3'(a); w[31:14] = 18'(imm);
    return w;
  endfunction

  // Reference sequencing model built from the requirements
  task automatic model_run(input int len, input logic [31:0] arg);
    logic [31:0] r [8];
    logic [31:0] w, a, b, imm, tt;
    int pc, kind, tgt, pi, nxt, nk;
    bit isb, tk, fetch, pop;
    for (int i = 0; i < 8; i++) r[i] = '0;
    r[1] = arg; pc = 0; kind = 0; tgt = 0; pi = 0; exp_n = 0; exp_err = 0;
    for (int step = 0; step < 400; step++) begin
      if ((pc >> 2) >= len) begin exp_err = 2; break; end
      w = prog_m[pc >> 2];
      if (w[2:0] == 3'd6) begin exp_err = 1; break; end
      isb = (w[2:0] == 3'd7);
      if (isb && kind != 0) begin exp_err = 3; break; end
      a = (w[13:11] == 3'd0) ? '0 : r[w[13:11]];
      b = (w[16:14] == 3'd0) ? '0 : r[w[16:14]];
      imm = {{14{w[31]}}, w[31:14]};
      if (!isb) begin
        if (exp_n < 256) begin
          exp_pc[exp_n] = pc; exp_a[exp_n] = a; exp_b[exp_n] = b;
        end
        exp_n = exp_n + 1;
        fetch = (w[6:4] == 3'd0) || (w[6:4] == 3'd3) || (w[6:4] == 3'd5);
        pop = fetch || (w[6:4] == 3'd6);
        if (w[10:8] != 3'd0) r[w[10:8]] = fetch ? pval(pi) : (a + b + imm);
        if (pop) pi = pi + 1;
      end
      if (kind == 2) break;
      nxt = (pc + 4) & PCMASK; nk = 0;
      if (kind == 1) begin
        nxt = tgt; nk = w[7] ? 2 : 0;
      end else if (isb) begin
        tk = w[4] ? (a != 0) : (a == 0);
        if (tk) begin
          tt = 32'(pc) + (imm << 2);
          if (w[5]) nxt = int'(tt) & PCMASK;
          else begin tgt = int'(tt) & PCMASK; nk = 1; end
        end else nk = w[7] ? 2 : 0;
      end else nk = w[7] ? 2 : 0;
      pc = nxt; kind = nk;
    end
  endtask

  task automatic load_prog(input int len);
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
      load_we = 1'b1; load_addr = IAW'(i); load_data = prog_m[i];
    end
    @(posedge clk); #1;
    load_we = 1'b0; prog_len = (IAW+1)'(len);
  endtask

  task automatic launch(input logic [31:0] arg);
    @(posedge clk); #1;
    start = 1'b1; start_arg = arg; pidx_clr = 1'b1;
    @(posedge clk); #1;
    start = 1'b0; pidx_clr = 1'b0;
  endtask

  task automatic finish_cmp(input string tag);
    int t = 0;
    do begin @(negedge clk); t++; end while (!done && t < 3000);
    chk(done, tag, "run reached done", 32'(done), 1);
    chk(int'(err_code) == exp_err, tag, "error code", 32'(err_code), 32'(exp_err));
    chk(got_n == exp_n, tag, "issue count", 32'(got_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < got_n && i < 256; i++) begin
      chk(got_pc[i] == exp_pc[i], tag, "issue pc", 32'(got_pc[i]), 32'(exp_pc[i]));
      chk(got_a[i] == exp_a[i], tag, "source a", got_a[i], exp_a[i]);
      chk(got_b[i] == exp_b[i], tag, "source b", got_b[i], exp_b[i]);
    end
    @(negedge clk);
    chk(!done && !busy, "R11", "done pulse width", {30'd0, done, busy}, 0);
  endtask

  task automatic run(input string tag, input int len, input logic [31:0] arg);
    load_prog(len);
    model_run(len, arg);
    launch(arg);
    finish_cmp(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors = errors + 1; checks = checks + 1;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit saw;
    void'($urandom(32'h00C0FFEE));
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !iss_valid && !param_pop && err_code == 0, "R11",
        "reset idle", {27'd0, busy, done, iss_valid, param_pop, 1'b0}, 0);

    // R2, R3, R1: straight line, write to r0 dropped, r1 holds argument
    prog_m[0] = mkop(0, 1, 0, 1, 1, 0);
    prog_m[1] = mkop(0, 1, 3, 0, 1, 1);
    prog_m[2] = mkop(0, 1, 0, 3, 0, 0);
    run("R3", 3, 32'h1234_5678);
    chk(got_a[1] == 0, "R3", "r0 reads zero", got_a[1], 0);
    chk(got_b[1] == 32'h1234_5678, "R1", "r1 holds start_arg", got_b[1], 32'h1234_5678);
    chk(got_pc[2] == 8, "R2", "pc steps by 4", 32'(got_pc[2]), 8);

    // R6: annulled taken branch skips the slot
    prog_m[0] = mkbr(0, 0, 1, 3, 0);
    prog_m[1] = mkop(0, 1, 2, 1, 1, 0);
    prog_m[2] = mkop(0, 1, 2, 1, 1, 0);
    prog_m[3] = mkop(1, 1, 4, 1, 0, 1);
    prog_m[4] = mkop(0, 1, 5, 4, 1, 0);
    run("R6", 5, 32'd7);
    chk(got_n == 2 && got_pc[0] == 12, "R6", "annul skips slot", 32'(got_pc[0]), 12);

    // R5: non-annulled taken branch runs the slot first
    prog_m[0] = mkbr(0, 0, 0, 3, 0);
    run("R5", 5, 32'd9);
    chk(got_n == 3 && got_pc[0] == 4 && got_pc[1] == 12, "R5", "slot then target",
        32'(got_pc[1]), 12);

    // R7: exit in a branch slot runs the target once
    prog_m[1] = mkop(0, 1, 2, 1, 1, 1);
    prog_m[3] = mkop(1, 1, 4, 1, 0, 0);
    run("R7", 5, 32'd3);
    chk(got_n == 2 && got_pc[1] == 12, "R7", "target after exit slot", 32'(got_pc[1]), 12);

    // R4: nonzero condition, taken and not taken
    prog_m[0] = mkbr(1, 1, 1, 2, 0);
    prog_m[1] = mkop(0, 1, 2, 1, 1, 0);
    prog_m[2] = mkop(0, 1, 3, 1, 1, 1);
    prog_m[3] = mkop(0, 1, 4, 3, 1, 0);
    run("R4", 4, 32'd5);
    chk(got_n == 2 && got_pc[0] == 8, "R4", "nonzero taken", 32'(got_pc[0]), 8);
    run("R4", 4, 32'd0);
    chk(got_n == 3 && got_pc[0] == 4, "R4", "nonzero not taken", 32'(got_pc[0]), 4);

    // R8: branch in a delay slot
    prog_m[0] = mkbr(0, 0, 0, 2, 0);
    prog_m[1] = mkbr(0, 0, 0, 2, 0);
    run("R8", 4, 32'd1);
    chk(err_code == 2'd3 && got_n == 0, "R8", "branch in slot", 32'(err_code), 3);

    // R9: reserved operation and fetch overrun
    prog_m[0] = mkop(0, 1, 2, 1, 1, 0);
    prog_m[1] = mkop(6, 1, 2, 1, 1, 0);
    run("R9", 3, 32'd2);
    chk(err_code == 2'd1 && got_n == 1, "R9", "reserved op", 32'(err_code), 1);
    prog_m[1] = mkop(0, 1, 3, 2, 1, 0);
    run("R9", 2, 32'd2);
    chk(err_code == 2'd2 && got_n == 2, "R9", "fetch overrun", 32'(err_code), 2);

    // R10 and R1: stall on empty FIFO, second start ignored
    prog_m[0] = mkop(0, 0, 2, 0, 0, 0);
    prog_m[1] = mkop(0, 1, 3, 2, 0, 1);
    prog_m[2] = mkop(0, 1, 0, 3, 0, 0);
    load_prog(3);
    model_run(3, 32'hAAAA_0001);
    pv_block = 1'b1;
    launch(32'hAAAA_0001);
    saw = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (iss_valid || !busy) saw = 1'b1;
    end
    chk(!saw, "R10", "stall while FIFO empty", 32'(saw), 0);
    @(posedge clk); #1; start = 1'b1; start_arg = 32'hBBBB_0002;
    @(posedge clk); #1; start = 1'b0;
    pv_block = 1'b0;
    finish_cmp("R1");
    chk(got_a[1] == pval(0), "R10", "fetched word written", got_a[1], pval(0));

    // Random programs against the model
    for (int p = 0; p < 30; p++) begin
      for (int i = 0; i < 12; i++) begin
        int r = int'($urandom % 32);
        logic [31:0] w = $urandom;
        if (r < 20) w[2:0] = 3'(r % 6);
        else if (r < 30) begin
          w[2:0] = 3'd7; w[31:14] = 18'(1 + ($urandom % 4));
        end else if (r == 30) w[2:0] = 3'd0;
        else w[2:0] = 3'd6;
        w[7] = (($urandom % 5) == 0);
        prog_m[i] = w;
      end
      run("R2", 12, $urandom);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule